// File: doc/BRIEF.md
# GPIO Interrupt Sense and Pending Controller

The block turns 32 already-synchronised GPIO inputs into interrupt requests. Software picks, for each pin, one of five trigger conditions: rising edge, falling edge, either edge, high level or low level. It also picks a faster sampling path that skips one register stage. A per-pin detect-enable gates whether an event can be latched at all. Latched events sit in a pending vector that software clears by writing ones.

A separate interrupt-enable vector masks the pending bits. It has its own set and clear addresses. Software reads both the raw and the masked pending vectors. It services the lowest set bit of the masked vector first and then clears that bit. The masked vector is reduced to two request lines: one for pins 0 to 15 and one for pins 16 to 31.

Rewriting a pin's trigger condition is safe while the pin is moving. For the next two cycles that pin's detection is suppressed. As a result, a comparison only ever uses samples taken under the new setting.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every readable register (0x14, 0x1C, 0x20, 0x24, 0x40 to 0x4C) reads zero and both request outputs are low.
- R2: Pin n's 4-bit trigger code lives in the register at 0x40 + 4*(n/8), in bits (n mod 8)*4 to (n mod 8)*4+3, and reads back as written.
- R3: Code bits [2:0] = 0 latches pending on a 0-to-1 transition of the pin.
- R4: Code bits [2:0] = 1 latches on a 1-to-0 transition, and = 4 latches on either transition.
- R5: Code bits [2:0] = 2 (high) or 3 (low) sets pending on every cycle the level holds, so a clear written while the level holds leaves the bit set.
- R6: While bit n of the detect-enable register (0x14, read/write) is 0, pin n never latches pending.
- R7: Writing to 0x28 clears exactly the pending bits written as 1; zero bits leave pending unchanged.
- R8: Writing ones to 0x18 sets interrupt-enable bits, writing ones to 0x1C clears them, and reading 0x1C returns the enable vector.
- R9: 0x20 reads the raw pending vector; 0x24 reads pending AND enable.
- R10: irq_lo_o is the OR of masked bits 15..0 and irq_hi_o the OR of masked bits 31..16.
- R11: With code bit 3 set, an edge is latched at the first clock edge after the pin changes. With bit 3 clear it is latched one clock later.
- R12: A write that changes a pin's code suppresses that pin's detection for two cycles, so no event arises from samples taken under the old code. Codes whose bits [2:0] are 5, 6 or 7 never latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when high together with req_i |
| addr_i | input | 8 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| pins_i | input | 32 | Synchronised GPIO input levels |
| irq_lo_o | output | 1 | Request for pins 0 to 15 |
| irq_hi_o | output | 1 | Request for pins 16 to 31 |

## Verification
Directed cases give each trigger kind its own pin. Toggling those pins separates rising, falling, both-edge and level behaviour, and a disabled pin and a pin with an unused code show that neither latches. Fast and slow pins are toggled together, so the one-cycle latency gap between the two paths is visible. A pin is raised in the same cycle its code is rewritten, which shows whether the suppression window works. A seeded random phase then drives arbitrary codes, enables and pin waveforms, with occasional clears. Raw, masked and request outputs are compared each cycle with a reference model that works from the trigger rules alone.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned SENSE_W   = 4;
  localparam int unsigned ASYNC_BIT = 3;

  typedef enum logic [2:0] {
    SNS_RISE = 3'd0,
    SNS_FALL = 3'd1,
    SNS_HIGH = 3'd2,
    SNS_LOW  = 3'd3,
    SNS_BOTH = 3'd4
  } sense_e;

  localparam int unsigned OFS_DET_EN   = 'h14;
  localparam int unsigned OFS_IEN_SET  = 'h18;
  localparam int unsigned OFS_IEN_CLR  = 'h1C;
  localparam int unsigned OFS_RAW      = 'h20;
  localparam int unsigned OFS_MASKED   = 'h24;
  localparam int unsigned OFS_PEND_CLR = 'h28;
  localparam int unsigned OFS_SENSE0   = 'h40;
endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N_PINS = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_i,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [N_PINS-1:0]          wdata_i,
  input  logic [N_PINS-1:0]          pend_i,
  output logic [N_PINS-1:0]          rdata_o,
  output logic [N_PINS-1:0]          det_en_o,
  output logic [N_PINS-1:0]          ien_o,
  output logic [N_PINS*SENSE_W-1:0]  sense_o,
  output logic [N_PINS-1:0]          sense_chg_o,
  output logic [N_PINS-1:0]          pend_clr_o
);
  localparam int unsigned DATA_W       = N_PINS;
  localparam int unsigned PINS_PER_REG = DATA_W / SENSE_W;
  localparam int unsigned N_SNS_REGS   = N_PINS / PINS_PER_REG;

  logic                  wr;
  logic [N_PINS-1:0]     det_en_q, ien_q;
  logic [N_PINS*SENSE_W-1:0] sense_q;
  logic [N_SNS_REGS-1:0] sns_hit;

  assign wr = req_i & we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      det_en_q <= '0;
      ien_q    <= '0;
    end else begin
      if (wr && addr_i == ADDR_W'(OFS_DET_EN)) det_en_q <= wdata_i;
      if (wr && addr_i == ADDR_W'(OFS_IEN_CLR))      ien_q <= ien_q & ~wdata_i;
      else if (wr && addr_i == ADDR_W'(OFS_IEN_SET)) ien_q <= ien_q | wdata_i;
    end
  end

  for (genvar k = 0; k < N_SNS_REGS; k++) begin : g_sns_reg
    assign sns_hit[k] = wr && addr_i == ADDR_W'(OFS_SENSE0 + 4 * k);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         sense_q[k*DATA_W +: DATA_W] <= '0;
      else if (sns_hit[k]) sense_q[k*DATA_W +: DATA_W] <= wdata_i;
    end
  end

  // a field counts as changed only when its value actually differs
  for (genvar n = 0; n < N_PINS; n++) begin : g_chg
    assign sense_chg_o[n] = sns_hit[n / PINS_PER_REG] &&
        (wdata_i[(n % PINS_PER_REG)*SENSE_W +: SENSE_W] != sense_q[n*SENSE_W +: SENSE_W]);
  end

  assign pend_clr_o = (wr && addr_i == ADDR_W'(OFS_PEND_CLR)) ? wdata_i : '0;

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(OFS_DET_EN)) rdata_o = det_en_q;
    if (addr_i == ADDR_W'(OFS_IEN_CLR)) rdata_o = ien_q;
    if (addr_i == ADDR_W'(OFS_RAW))    rdata_o = pend_i;
    if (addr_i == ADDR_W'(OFS_MASKED)) rdata_o = pend_i & ien_q;
    for (int k = 0; k < N_SNS_REGS; k++)
      if (addr_i == ADDR_W'(OFS_SENSE0 + 4 * k)) rdata_o = sense_q[k*DATA_W +: DATA_W];
  end

  assign det_en_o = det_en_q;
  assign ien_o    = ien_q;
  assign sense_o  = sense_q;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N_PINS   = 32,
  parameter int unsigned HOLD_CYC = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_PINS-1:0]         pins_i,
  input  logic [N_PINS*SENSE_W-1:0] sense_i,
  input  logic [N_PINS-1:0]         det_en_i,
  input  logic [N_PINS-1:0]         sense_chg_i,
  output logic [N_PINS-1:0]         evt_o
);
  localparam int unsigned HOLD_W = $clog2(HOLD_CYC + 1);

  logic [N_PINS-1:0] smp1_q, smp2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp1_q <= '0;
      smp2_q <= '0;
    end else begin
      smp1_q <= pins_i;
      smp2_q <= smp1_q;
    end
  end

  for (genvar n = 0; n < N_PINS; n++) begin : g_pin
    logic [SENSE_W-1:0] code;
    logic               cur, prev, hit;
    logic [HOLD_W-1:0]  hold_q;

    assign code = sense_i[n*SENSE_W +: SENSE_W];
    // fast path compares the live pin with one stored sample
    assign cur  = code[ASYNC_BIT] ? pins_i[n] : smp1_q[n];
    assign prev = code[ASYNC_BIT] ? smp1_q[n] : smp2_q[n];

    always_comb begin
      case (sense_e'(code[2:0]))
        SNS_RISE: hit = cur & ~prev;
        SNS_FALL: hit = ~cur & prev;
        SNS_HIGH: hit = cur;
        SNS_LOW:  hit = ~cur;
        SNS_BOTH: hit = cur ^ prev;
        default:  hit = 1'b0;
      endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             hold_q <= '0;
      else if (sense_chg_i[n]) hold_q <= HOLD_W'(HOLD_CYC);
      else if (hold_q != '0)   hold_q <= hold_q - 1'b1;
    end

    assign evt_o[n] = det_en_i[n] & (hold_q == '0) & hit;
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N_PINS = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_PINS-1:0] wdata_i,
  output logic [N_PINS-1:0] rdata_o,
  input  logic [N_PINS-1:0] pins_i,
  output logic              irq_lo_o,
  output logic              irq_hi_o
);
  localparam int unsigned HALF = N_PINS / 2;

  logic [N_PINS-1:0]         pend_q, ien_q, det_en_q, evt, sense_chg, pend_clr, masked;
  logic [N_PINS*SENSE_W-1:0] sense;

  gpio_irq_regs #(.N_PINS(N_PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .pend_i      (pend_q),
    .rdata_o,
    .det_en_o    (det_en_q),
    .ien_o       (ien_q),
    .sense_o     (sense),
    .sense_chg_o (sense_chg),
    .pend_clr_o  (pend_clr)
  );

  gpio_irq_detect #(.N_PINS(N_PINS)) u_det (
    .clk_i, .rst_ni, .pins_i,
    .sense_i     (sense),
    .det_en_i    (det_en_q),
    .sense_chg_i (sense_chg),
    .evt_o       (evt)
  );

  // a new event outranks a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~pend_clr) | evt;
  end

  assign masked   = pend_q & ien_q;
  assign irq_lo_o = |masked[HALF-1:0];
  assign irq_hi_o = |masked[N_PINS-1:HALF];
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
  parameter int unsigned N_PINS = 32,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [N_PINS-1:0] wdata_i,
  input logic              irq_lo_o,
  input logic              irq_hi_o,
  input logic [N_PINS-1:0] pend_q,
  input logic [N_PINS-1:0] ien_q,
  input logic [N_PINS-1:0] det_en_q,
  input logic [N_PINS-1:0] evt,
  input logic [N_PINS-1:0] sense_chg
);
  logic wr_clr, wr_set;
  assign wr_clr = req_i && we_i && addr_i == ADDR_W'('h28);
  assign wr_set = req_i && we_i && addr_i == ADDR_W'('h18);

  p_latch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt) |=> ((pend_q & $past(evt)) == $past(evt)));

  p_det_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_q & ~$past(pend_q) & ~$past(det_en_q)) == '0));

  p_w1c_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr |=> ((pend_q & $past(wdata_i & ~evt)) == '0));

  p_ien_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_set |=> ((ien_q & $past(wdata_i)) == $past(wdata_i)));

  p_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_q == '0) |-> (!irq_lo_o && !irq_hi_o));

  p_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|sense_chg) |=> ((evt & $past(sense_chg)) == '0));
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.N_PINS(N_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .irq_lo_o  (irq_lo_o),
  .irq_hi_o  (irq_hi_o),
  .pend_q    (pend_q),
  .ien_q     (ien_q),
  .det_en_q  (det_en_q),
  .evt       (evt),
  .sense_chg (sense_chg)
);

// File: tb/gpio_irq_ctrl_test.sv
module gpio_irq_ctrl_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0, pins_i = '0;
  logic [31:0] rdata_o;
  logic        irq_lo_o, irq_hi_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  gpio_irq_ctrl uut (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .rdata_o, .pins_i, .irq_lo_o, .irq_hi_o
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr_i = a; #1; d = rdata_o;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // reference trigger rules
  function automatic logic [31:0] model_ev(logic [31:0] h0, logic [31:0] h1,
                                           logic [31:0] h2, logic [127:0] sns);
    logic [31:0] ev = '0;
    for (int n = 0; n < 32; n++) begin
      logic [3:0] c = sns[n*4 +: 4];
      logic cu = c[3] ? h0[n] : h1[n];
      logic pr = c[3] ? h1[n] : h2[n];
      case (c[2:0])
        3'd0: ev[n] = cu & ~pr;
        3'd1: ev[n] = ~cu & pr;
        3'd2: ev[n] = cu;
        3'd3: ev[n] = ~cu;
        3'd4: ev[n] = cu ^ pr;
        default: ev[n] = 1'b0;
      endcase
    end
    return ev;
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, h0, h1, h2, det_m, ien_m, pend_m, clr;
    logic [127:0] sns_m;
    void'($urandom(32'd20240611));
    cyc(3);
    rst_ni = 1'b1;
    cyc(1);

    // R1 reset state
    foreach (d[i]) ; // no-op keeps d declared use simple
    rd(8'h14, d); chk("R1 det_en", d, 0);
    rd(8'h1C, d); chk("R1 ien", d, 0);
    rd(8'h20, d); chk("R1 raw", d, 0);
    rd(8'h24, d); chk("R1 masked", d, 0);
    for (int k = 0; k < 4; k++) begin
      rd(8'h40 + 8'(4*k), d); chk("R1 sense", d, 0);
    end
    chk("R1 irq", {30'd0, irq_hi_o, irq_lo_o}, 0);

    // R2 layout: pin7..0 codes D,8,B,A,C,9,0,8 ; pin8 = 9 ; pin17 = 8
    pins_i = 32'h0000_0004;
    wr(8'h40, 32'hD8BA_C908);
    wr(8'h44, 32'h0000_0009);
    wr(8'h48, 32'h0000_0080);
    rd(8'h40, d); chk("R2 sense reg0", d, 32'hD8BA_C908);
    rd(8'h44, d); chk("R2 sense reg1", d, 32'h0000_0009);
    rd(8'h48, d); chk("R2 sense reg2", d, 32'h0000_0080);
    wr(8'h14, 32'h0002_01BF);
    rd(8'h14, d); chk("R6 det_en readback", d, 32'h0002_01BF);
    cyc(3);

    // R5 low level on pin5 survives a clear
    wr(8'h28, 32'hFFFF_FFFF);
    rd(8'h20, d); chk("R5 low level reasserts", d, 32'h20);
    pins_i = 32'h24; cyc(1);
    wr(8'h28, 32'hFFFF_FFFF);
    rd(8'h20, d); chk("R7 clear all", d, 0);

    // R3/R11: pin0 fast rise, pin1 slow rise; pin6 disabled, pin7 unused code
    pins_i = 32'hE7; cyc(1);
    rd(8'h20, d); chk("R11 fast path first edge", d, 32'h1);
    cyc(1);
    rd(8'h20, d); chk("R11 slow path second edge", d, 32'h3);
    chk("R6 R12 disabled and unused code", d & 32'hC0, 0);
    cyc(3);
    rd(8'h20, d); chk("R6 pin6 and pin7 still clear", d & 32'hC0, 0);

    // R7 write-one-to-clear
    wr(8'h28, 32'h0);
    rd(8'h20, d); chk("R7 zero write no effect", d, 32'h3);
    wr(8'h28, 32'h1);
    rd(8'h20, d); chk("R7 clear bit0 only", d, 32'h2);
    wr(8'h28, 32'h2);
    rd(8'h20, d); chk("R7 clear bit1", d, 0);

    // R4 falling (pin2) and both (pin3)
    pins_i = 32'hE3; cyc(1);
    rd(8'h20, d); chk("R4 falling", d, 32'h4);
    wr(8'h28, 32'h4);
    pins_i = 32'hEB; cyc(1);
    rd(8'h20, d); chk("R4 both rising", d, 32'h8);
    wr(8'h28, 32'h8);
    pins_i = 32'hE3; cyc(1);
    rd(8'h20, d); chk("R4 both falling", d, 32'h8);
    wr(8'h28, 32'h8);

    // R5 high level on pin4
    pins_i = 32'hF3; cyc(1);
    rd(8'h20, d); chk("R5 high level", d, 32'h10);
    wr(8'h28, 32'h10);
    rd(8'h20, d); chk("R5 clear while high", d, 32'h10);
    pins_i = 32'hE3; cyc(1);
    wr(8'h28, 32'h10);
    rd(8'h20, d); chk("R5 clear after drop", d, 0);

    // R3 pin17 from register 0x48 field bits 7:4
    pins_i = 32'h0002_00E3; cyc(1);
    rd(8'h20, d); chk("R3 pin17 rise", d, 32'h0002_0000);

    // R8 / R9 / R10 enables and masking
    wr(8'h18, 32'h0002_0001);
    rd(8'h1C, d); chk("R8 set", d, 32'h0002_0001);
    rd(8'h24, d); chk("R9 masked", d, 32'h0002_0000);
    chk("R10 hi only", {30'd0, irq_hi_o, irq_lo_o}, 32'h2);
    wr(8'h1C, 32'h0002_0000);
    rd(8'h1C, d); chk("R8 clear", d, 32'h1);
    rd(8'h24, d); chk("R9 masked after clear", d, 0);
    chk("R10 none", {30'd0, irq_hi_o, irq_lo_o}, 0);
    pins_i = 32'h0002_00E2; cyc(1);
    pins_i = 32'h0002_00E3; cyc(1);
    rd(8'h20, d); chk("R9 raw", d, 32'h0002_0001);
    chk("R10 lo only", {30'd0, irq_hi_o, irq_lo_o}, 32'h1);
    wr(8'h28, 32'hFFFF_FFFF);

    // R12 pin8 raised in the same cycle its code changes to slow rising
    pins_i = 32'h0002_01E3;
    wr(8'h44, 32'h0);
    cyc(3);
    rd(8'h20, d); chk("R12 no spurious event", d, 0);
    pins_i = 32'h0002_00E3; cyc(3);
    pins_i = 32'h0002_01E3; cyc(2);
    rd(8'h20, d); chk("R12 armed after window", d, 32'h100);

    // random phase
    rst_ni = 1'b0; cyc(2); rst_ni = 1'b1; cyc(1);
    h0 = $urandom; pins_i = h0;
    for (int k = 0; k < 4; k++) begin
      sns_m[k*32 +: 32] = $urandom;
      wr(8'h40 + 8'(4*k), sns_m[k*32 +: 32]);
    end
    det_m = $urandom; ien_m = $urandom;
    wr(8'h14, det_m);
    wr(8'h18, ien_m);
    cyc(3);
    wr(8'h28, 32'hFFFF_FFFF);
    h1 = h0; h2 = h0;
    pend_m = model_ev(h0, h1, h2, sns_m) & det_m;
    for (int it = 0; it < 300; it++) begin
      rd(8'h20, d); chk("R3 R4 R5 random raw", d, pend_m);
      rd(8'h24, d); chk("R9 random masked", d, pend_m & ien_m);
      chk("R10 random irq", {30'd0, irq_hi_o, irq_lo_o},
          {30'd0, |(pend_m[31:16] & ien_m[31:16]), |(pend_m[15:0] & ien_m[15:0])});
      h2 = h1; h1 = h0;
      h0 = ($urandom % 2) ? $urandom : h1;
      clr = ($urandom % 4 == 0) ? $urandom : 32'h0;
      pins_i = h0;
      if (clr != 0) begin
        req_i = 1'b1; we_i = 1'b1; addr_i = 8'h28; wdata_i = clr;
      end
      @(negedge clk_i);
      req_i = 1'b0; we_i = 1'b0;
      pend_m = (pend_m & ~clr) | (model_ev(h0, h1, h2, sns_m) & det_m);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule